// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Unit

This unit sits beside the execute stage of a small 8-bit processor and owns two of its architectural registers: the interrupt status byte (register slot 6) and the interrupt mask byte (register slot 5). Slot 7 is the stack pointer, which the unit reads and writes through its own port. Event sources set bits in the status byte: a one-cycle timer tick pulse sets bit 0, and a software-interrupt request sets the bit whose index it carries. A bit is pending when it is set in both status and mask.

Whenever the processor is about to fetch an instruction, it raises `fetch_req`. If any bit is pending, the unit asserts `busy` to stall the fetch. It then saves the machine context onto the byte stack, one memory write per cycle, and jumps to a handler. The handler address is read from a vector table at 0xF8 plus the bit number. All interrupts are then masked. A return request runs the opposite sequence: it restores the saved context and unmasks every source.

The register count, data width, vector base and tick source are parameters. The default configuration (five general registers R0 to R4, 8-bit data, external tick) matches the processor described above.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, status and mask are 0x00, `busy` is low, and the unit issues no memory, stack pointer, register, flags or PC write.
- R2: A one-cycle `tick_in` pulse sets status bit 0. A `swi_req` pulse sets status bit `swi_num`. Bits already set stay set.
- R3: In an idle cycle with `fetch_req` high and (status AND mask) non-zero, the unit raises `busy` in that same cycle and starts an entry sequence. It selects the lowest-numbered pending bit as interrupt number n.
- R4: The entry sequence makes nine pushes, one per cycle, in this order: PC, flags, R0, R1, R2, R3, R4, the mask value held at the take, and the status value after the clear of R6. Each push first decrements the stack pointer and then writes memory at the new value. The first push therefore lands at `sp_in`-1, and `sp_out`/`sp_we` report each new stack pointer.
- R5: After the pushes, the unit reads memory at 0xF8+n and loads that byte into the PC, then clears the mask to 0x00. `busy` is high for 11 cycles counting the take cycle.
- R6: The serviced status bit is cleared at the take, and other status bits are kept. If a source sets that same bit in the take cycle, the bit stays set.
- R7: In an idle cycle with `iret_req` high, the unit makes nine pops, one per cycle. Each pop reads memory at the stack pointer and then increments it. The pops fill, in order: status, mask, R4 down to R0, flags, and PC. The mask is then set to 0xFF. `busy` is high for 10 cycles counting the request cycle.
- R8: When `iret_req` and `fetch_req` are both high in one idle cycle, the return sequence runs and no interrupt is taken.
- R9: `mask_we` loads `mask_wdata` into the mask at the next clock edge.
- R10: With mask 0x00, `fetch_req` does not start a sequence, whatever the status byte holds.
- R11: An entry followed by a return restores R0 to R4, the flags, the PC and the stack pointer to their values before the entry.
- R12: Only one interrupt is taken per fetch check. After the return, the next `fetch_req` takes the next-lowest pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Processor is about to fetch; interrupt check point |
| iret_req | input | 1 | Return-from-interrupt request from execute |
| busy | output | 1 | Stall fetch and execute while high |
| tick_in | input | 1 | Timer tick pulse, sets status bit 0 |
| swi_req | input | 1 | Software interrupt request |
| swi_num | input | 3 | Status bit index to set on `swi_req` |
| mask_we | input | 1 | Processor write of the mask register |
| mask_wdata | input | 8 | Value for a mask write |
| irq_mask | output | 8 | Current mask register (register slot 5) |
| irq_status | output | 8 | Current status register (register slot 6) |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as the address |
| sp_in | input | 8 | Current stack pointer |
| sp_out | output | 8 | New stack pointer |
| sp_we | output | 1 | Stack pointer write strobe |
| rf_raddr | output | 3 | General register read index |
| rf_rdata | input | 8 | General register read data, same cycle |
| rf_waddr | output | 3 | General register write index |
| rf_wdata | output | 8 | General register write data |
| rf_we | output | 1 | General register write strobe |
| flags_in | input | 8 | Current flags byte |
| flags_out | output | 8 | Restored flags byte |
| flags_we | output | 1 | Flags write strobe |
| pc_in | input | 8 | Current PC |
| pc_out | output | 8 | New PC |
| pc_we | output | 1 | PC write strobe |

## Verification
Two situations are hard to reach. The first is a source setting the very bit being cleared in the take cycle. The second is a return request arriving in the same cycle as a fetch check while an interrupt is pending. Only exact cycle alignment reaches either one. The bench drives both requests on one falling edge, so they meet at the same rising edge. It then reads the outcome through the status output, the restored PC and the length of the `busy` window. The stacked status and mask values are checked byte by byte in the bench's memory model, and then again after a full entry and return.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PUSH = 2'd1,
      ST_VEC  = 2'd2,
      ST_POP  = 2'd3
   } seq_state_t;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
   parameter int DATA_W      = 8,
   parameter bit EXT_TICK    = 1'b1,
   parameter int TICK_PERIOD = 1000,
   localparam int IDX_W      = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_in,
   input  logic              swi_req,
   input  logic [IDX_W-1:0]  swi_num,
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  clr_idx,
   input  logic              stat_ld_en,
   input  logic [DATA_W-1:0] stat_ld_val,
   input  logic              mask_ld_en,
   input  logic [DATA_W-1:0] mask_ld_val,
   input  logic              mask_we,
   input  logic [DATA_W-1:0] mask_wdata,
   output logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] mask_q
);
   logic              tick;
   logic [DATA_W-1:0] set_bits;
   logic [DATA_W-1:0] clr_bits;

   generate
      if (EXT_TICK) begin : g_ext_tick
         assign tick = tick_in;
      end else begin : g_int_tick
         localparam int TW = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
         logic [TW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              div_q <= '0;
            else if (div_q == TW'(TICK_PERIOD - 1))  div_q <= '0;
            else                                     div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == TW'(TICK_PERIOD - 1));
      end
   endgenerate

   always_comb begin
      set_bits = '0;
      clr_bits = '0;
      if (tick)    set_bits[0]       = 1'b1;
      if (swi_req) set_bits[swi_num] = 1'b1;
      if (clr_en)  clr_bits[clr_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= '0;
      end else begin
         status_q <= (stat_ld_en ? stat_ld_val : (status_q & ~clr_bits)) | set_bits;
         if (mask_ld_en)   mask_q <= mask_ld_val;
         else if (mask_we) mask_q <= mask_wdata;
      end
   end

   assert_tick_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> status_q[0]);

   assert_clear_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !stat_ld_en && !set_bits[clr_idx]) |=> !status_q[$past(clr_idx)]);
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] status_q,
   input  logic [DATA_W-1:0] mask_q,
   output logic              any,
   output logic [IDX_W-1:0]  idx
);
   logic [DATA_W-1:0] pend;

   assign pend = status_q & mask_q;
   assign any  = |pend;

   always_comb begin
      idx = '0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         if (pend[i]) idx = IDX_W'(i);
      end
   end

   assert_lowest_pick_R12: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (pend[idx] && ((pend & ~({DATA_W{1'b1}} << idx)) == '0)));
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
   import irq_dispatch_pkg::*;
#(
   parameter int           DATA_W   = 8,
   parameter int           GPR_N    = 5,
   parameter logic [7:0]   VEC_BASE = 8'hF8,
   localparam int IDX_W  = $clog2(DATA_W),
   localparam int LAST   = GPR_N + 3,
   localparam int CNT_W  = $clog2(LAST + 1),
   localparam int RIDX_W = $clog2(GPR_N + 3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic              iret_req,
   input  logic              pend_any,
   input  logic [IDX_W-1:0]  pend_idx,
   input  logic [DATA_W-1:0] mask_q,
   input  logic [DATA_W-1:0] status_q,
   output logic              busy,
   output logic              clr_en,
   output logic [IDX_W-1:0]  clr_idx,
   output logic              stat_ld_en,
   output logic [DATA_W-1:0] stat_ld_val,
   output logic              mask_ld_en,
   output logic [DATA_W-1:0] mask_ld_val,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] sp_in,
   output logic [DATA_W-1:0] sp_out,
   output logic              sp_we,
   output logic [RIDX_W-1:0] rf_raddr,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic [RIDX_W-1:0] rf_waddr,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              rf_we,
   input  logic [DATA_W-1:0] flags_in,
   output logic [DATA_W-1:0] flags_out,
   output logic              flags_we,
   input  logic [DATA_W-1:0] pc_in,
   output logic [DATA_W-1:0] pc_out,
   output logic              pc_we
);
   seq_state_t        st;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sp_r;
   logic [IDX_W-1:0]  num;
   logic              take, ret_go, last;
   logic [DATA_W-1:0] push_item;

   assign last   = (cnt == CNT_W'(LAST));
   assign ret_go = (st == ST_IDLE) && iret_req;
   assign take   = (st == ST_IDLE) && !iret_req && fetch_req && pend_any;
   assign busy   = (st != ST_IDLE) || take || ret_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         sp_r <= '0;
         num  <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               cnt  <= '0;
               sp_r <= sp_in;
               if (ret_go)    st <= ST_POP;
               else if (take) begin
                  st  <= ST_PUSH;
                  num <= pend_idx;
               end
            end
            ST_PUSH: begin
               sp_r <= sp_r - 1'b1;
               cnt  <= cnt + 1'b1;
               if (last) st <= ST_VEC;
            end
            ST_VEC:  st <= ST_IDLE;
            ST_POP: begin
               sp_r <= sp_r + 1'b1;
               cnt  <= cnt + 1'b1;
               if (last) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      if (cnt == CNT_W'(0))                push_item = pc_in;
      else if (cnt == CNT_W'(1))           push_item = flags_in;
      else if (cnt <= CNT_W'(GPR_N + 1))   push_item = rf_rdata;
      else if (cnt == CNT_W'(GPR_N + 2))   push_item = mask_q;
      else                                 push_item = status_q;
   end

   assign clr_en    = take;
   assign clr_idx   = pend_idx;
   assign rf_raddr  = RIDX_W'(cnt - CNT_W'(2));
   assign rf_waddr  = RIDX_W'(CNT_W'(GPR_N + 1) - cnt);
   assign rf_wdata  = mem_rdata;
   assign flags_out = mem_rdata;
   assign pc_out    = mem_rdata;
   assign stat_ld_val = mem_rdata;
   assign mem_wdata = push_item;

   always_comb begin
      mem_addr    = '0;
      mem_we      = 1'b0;
      mem_re      = 1'b0;
      sp_out      = sp_r;
      sp_we       = 1'b0;
      rf_we       = 1'b0;
      flags_we    = 1'b0;
      pc_we       = 1'b0;
      stat_ld_en  = 1'b0;
      mask_ld_en  = 1'b0;
      mask_ld_val = '0;
      case (st)
         ST_PUSH: begin
            mem_addr = sp_r - 1'b1;
            mem_we   = 1'b1;
            sp_out   = sp_r - 1'b1;
            sp_we    = 1'b1;
         end
         ST_VEC: begin
            mem_addr   = DATA_W'(VEC_BASE) + DATA_W'(num);
            mem_re     = 1'b1;
            pc_we      = 1'b1;
            mask_ld_en = 1'b1;
         end
         ST_POP: begin
            mem_addr = sp_r;
            mem_re   = 1'b1;
            sp_out   = sp_r + 1'b1;
            sp_we    = 1'b1;
            if (cnt == CNT_W'(0))              stat_ld_en = 1'b1;
            else if (cnt == CNT_W'(1)) begin
               mask_ld_en  = 1'b1;
               mask_ld_val = mem_rdata;
            end
            else if (cnt <= CNT_W'(GPR_N + 1)) rf_we    = 1'b1;
            else if (cnt == CNT_W'(GPR_N + 2)) flags_we = 1'b1;
            else begin
               pc_we       = 1'b1;
               mask_ld_en  = 1'b1;
               mask_ld_val = '1;
            end
         end
         default: ;
      endcase
   end

   assert_entry_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_VEC) |=> (mask_q == '0));

   assert_return_unmasks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_POP && last) |=> (&mask_q));

   assert_one_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_pc_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pc_we |-> busy);

   assert_no_take_when_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && fetch_req && mask_q == '0) |=> (st != ST_PUSH));
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
   parameter int         DATA_W      = 8,
   parameter int         GPR_N       = 5,
   parameter logic [7:0] VEC_BASE    = 8'hF8,
   parameter bit         EXT_TICK    = 1'b1,
   parameter int         TICK_PERIOD = 1000,
   localparam int IDX_W  = $clog2(DATA_W),
   localparam int RIDX_W = $clog2(GPR_N + 3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic              iret_req,
   output logic              busy,
   input  logic              tick_in,
   input  logic              swi_req,
   input  logic [IDX_W-1:0]  swi_num,
   input  logic              mask_we,
   input  logic [DATA_W-1:0] mask_wdata,
   output logic [DATA_W-1:0] irq_mask,
   output logic [DATA_W-1:0] irq_status,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] sp_in,
   output logic [DATA_W-1:0] sp_out,
   output logic              sp_we,
   output logic [RIDX_W-1:0] rf_raddr,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic [RIDX_W-1:0] rf_waddr,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              rf_we,
   input  logic [DATA_W-1:0] flags_in,
   output logic [DATA_W-1:0] flags_out,
   output logic              flags_we,
   input  logic [DATA_W-1:0] pc_in,
   output logic [DATA_W-1:0] pc_out,
   output logic              pc_we
);
   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("irq_dispatch: DATA_W must be a power of two of at least 8");
      end
      if (GPR_N < 1) begin : g_bad_gpr
         $error("irq_dispatch: GPR_N must be at least 1");
      end
      if (!EXT_TICK && TICK_PERIOD < 2) begin : g_bad_period
         $error("irq_dispatch: TICK_PERIOD must be at least 2");
      end
   endgenerate

   logic              pend_any;
   logic [IDX_W-1:0]  pend_idx;
   logic              clr_en, stat_ld_en, mask_ld_en;
   logic [IDX_W-1:0]  clr_idx;
   logic [DATA_W-1:0] stat_ld_val, mask_ld_val;

   irq_src_regs #(.DATA_W(DATA_W), .EXT_TICK(EXT_TICK), .TICK_PERIOD(TICK_PERIOD)) u_src (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .swi_req(swi_req), .swi_num(swi_num),
      .clr_en(clr_en), .clr_idx(clr_idx), .stat_ld_en(stat_ld_en), .stat_ld_val(stat_ld_val),
      .mask_ld_en(mask_ld_en), .mask_ld_val(mask_ld_val), .mask_we(mask_we),
      .mask_wdata(mask_wdata), .status_q(irq_status), .mask_q(irq_mask));

   irq_lowest_pick #(.DATA_W(DATA_W)) u_pick (
      .clk(clk), .rst_n(rst_n), .status_q(irq_status), .mask_q(irq_mask),
      .any(pend_any), .idx(pend_idx));

   irq_ctx_seq #(.DATA_W(DATA_W), .GPR_N(GPR_N), .VEC_BASE(VEC_BASE)) u_seq (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .iret_req(iret_req),
      .pend_any(pend_any), .pend_idx(pend_idx), .mask_q(irq_mask), .status_q(irq_status),
      .busy(busy), .clr_en(clr_en), .clr_idx(clr_idx), .stat_ld_en(stat_ld_en),
      .stat_ld_val(stat_ld_val), .mask_ld_en(mask_ld_en), .mask_ld_val(mask_ld_val),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
      .mem_rdata(mem_rdata), .sp_in(sp_in), .sp_out(sp_out), .sp_we(sp_we),
      .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .rf_we(rf_we), .flags_in(flags_in), .flags_out(flags_out), .flags_we(flags_we),
      .pc_in(pc_in), .pc_out(pc_out), .pc_we(pc_we));
endmodule

// File: tb/sim_irq_dispatch.sv
`timescale 1ns/1ps
module sim_irq_dispatch;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fetch_req = 1'b0, iret_req = 1'b0, tick_in = 1'b0, swi_req = 1'b0;
   logic [2:0] swi_num = '0;
   logic       mask_we = 1'b0;
   logic [7:0] mask_wdata = '0;
   logic       busy, mem_we, mem_re, sp_we, rf_we, flags_we, pc_we;
   logic [7:0] irq_mask, irq_status, mem_addr, mem_wdata, mem_rdata, sp_out;
   logic [7:0] rf_rdata, rf_wdata, flags_out, pc_out;
   logic [2:0] rf_raddr, rf_waddr;

   logic [7:0] mem [0:255];
   logic [7:0] gpr [0:4];
   logic [7:0] sp_m, flags_m, pc_m;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   assign mem_rdata = mem[mem_addr];
   assign rf_rdata  = (rf_raddr < 3'd5) ? gpr[rf_raddr] : 8'h00;

   always @(posedge clk) begin
      if (mem_we)   mem[mem_addr] <= mem_wdata;
      if (rf_we && rf_waddr < 3'd5) gpr[rf_waddr] <= rf_wdata;
      if (sp_we)    sp_m    <= sp_out;
      if (flags_we) flags_m <= flags_out;
      if (pc_we)    pc_m    <= pc_out;
   end

   irq_dispatch u0 (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .iret_req(iret_req), .busy(busy),
      .tick_in(tick_in), .swi_req(swi_req), .swi_num(swi_num), .mask_we(mask_we),
      .mask_wdata(mask_wdata), .irq_mask(irq_mask), .irq_status(irq_status),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
      .mem_rdata(mem_rdata), .sp_in(sp_m), .sp_out(sp_out), .sp_we(sp_we),
      .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .rf_we(rf_we), .flags_in(flags_m), .flags_out(flags_out), .flags_we(flags_we),
      .pc_in(pc_m), .pc_out(pc_out), .pc_we(pc_we));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_swi(input logic [2:0] n);
      @(negedge clk); swi_req = 1'b1; swi_num = n;
      @(negedge clk); swi_req = 1'b0;
   endtask

   // drive a request on one falling edge and count the cycles busy stays high
   task automatic run_seq(input logic f, input logic r, input logic s, input logic [2:0] sn,
                          output int ncyc);
      ncyc = 0;
      @(negedge clk);
      fetch_req = f; iret_req = r; swi_req = s; swi_num = sn;
      #1;
      if (busy) ncyc++;
      @(negedge clk);
      fetch_req = 1'b0; iret_req = 1'b0; swi_req = 1'b0;
      #1;
      while (busy && ncyc < 50) begin
         ncyc++;
         @(negedge clk); #1;
      end
   endtask

   task automatic t_reset();
      chk("R1 status", irq_status, 8'h00);
      chk("R1 mask", irq_mask, 8'h00);
      chk("R1 busy", busy, 0);
      chk("R1 no writes", {mem_we, sp_we, rf_we, flags_we, pc_we}, 0);
   endtask

   task automatic t_sources();
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
      chk("R2 tick sets bit0", irq_status, 8'h01);
      pulse_swi(3'd3);
      chk("R2 swi sets bit3", irq_status, 8'h09);
   endtask

   task automatic t_masked();
      @(negedge clk); fetch_req = 1'b1;
      #1 chk("R10 no busy with mask 0", busy, 0);
      @(negedge clk); fetch_req = 1'b0;
      chk("R10 pc untouched", pc_m, 8'h40);
      chk("R10 sp untouched", sp_m, 8'hF4);
   endtask

   task automatic t_mask_write();
      @(negedge clk); mask_we = 1'b1; mask_wdata = 8'h0A;
      @(negedge clk); mask_we = 1'b0;
      chk("R9 mask write", irq_mask, 8'h0A);
   endtask

   task automatic t_entry();
      int n;
      run_seq(1'b1, 1'b0, 1'b0, 3'd0, n);
      chk("R3 R5 entry busy cycles", n, 11);
      chk("R4 push pc", mem[8'hF3], 8'h40);
      chk("R4 push flags", mem[8'hF2], 8'h02);
      for (int i = 0; i < 5; i++) chk("R4 push gpr", mem[8'hF1 - i], 8'h11 * (i + 1));
      chk("R4 push mask", mem[8'hEC], 8'h0A);
      chk("R4 R6 push status after clear", mem[8'hEB], 8'h01);
      chk("R4 final sp", sp_m, 8'hEB);
      chk("R3 R5 vector for bit3", pc_m, 8'h77);
      chk("R5 mask cleared", irq_mask, 8'h00);
      chk("R6 serviced bit cleared", irq_status, 8'h01);
   endtask

   task automatic t_return();
      int n;
      for (int i = 0; i < 5; i++) gpr[i] = 8'h00;
      flags_m = 8'h00; pc_m = 8'h99;
      pulse_swi(3'd7);
      run_seq(1'b0, 1'b1, 1'b0, 3'd0, n);
      chk("R7 return busy cycles", n, 10);
      for (int i = 0; i < 5; i++) chk("R11 gpr restored", gpr[i], 8'h11 * (i + 1));
      chk("R11 flags restored", flags_m, 8'h02);
      chk("R11 pc restored", pc_m, 8'h40);
      chk("R11 sp restored", sp_m, 8'hF4);
      chk("R7 mask all ones", irq_mask, 8'hFF);
      chk("R7 status popped", irq_status, 8'h01);
   endtask

   task automatic t_priority();
      int n;
      pulse_swi(3'd4);
      pulse_swi(3'd2);
      chk("R2 bits accumulate", irq_status, 8'h15);
      run_seq(1'b1, 1'b0, 1'b0, 3'd0, n);
      chk("R12 lowest bit vector", pc_m, 8'h20);
      chk("R12 one taken per check", irq_status, 8'h14);
      chk("R12 stacked status", mem[8'hEB], 8'h14);
   endtask

   task automatic t_iret_wins();
      int n;
      @(negedge clk); mask_we = 1'b1; mask_wdata = 8'hFF;
      @(negedge clk); mask_we = 1'b0;
      run_seq(1'b1, 1'b1, 1'b0, 3'd0, n);
      chk("R8 return chosen cycles", n, 10);
      chk("R8 pc from stack", pc_m, 8'h40);
      chk("R8 no take status", irq_status, 8'h14);
      chk("R8 mask all ones", irq_mask, 8'hFF);
   endtask

   task automatic t_same_cycle_set();
      int n;
      run_seq(1'b1, 1'b0, 1'b1, 3'd2, n);
      chk("R6 entry cycles", n, 11);
      chk("R6 bit2 vector", pc_m, 8'h66);
      chk("R6 same-cycle set kept", irq_status, 8'h14);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      for (int i = 0; i < 5; i++) gpr[i] = 8'h11 * (i + 1);
      sp_m = 8'hF4; flags_m = 8'h02; pc_m = 8'h40;
      mem[8'hF8] = 8'h20; mem[8'hFA] = 8'h66; mem[8'hFB] = 8'h77;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sources();
      t_masked();
      t_mask_write();
      t_entry();
      t_return();
      t_priority();
      t_iret_wins();
      t_same_cycle_set();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule